// File: doc/BRIEF.md
# Tagged Future File Rename Unit

This block performs register renaming for an out-of-order core without a free list and without reading the reorder buffer for operands. It holds two copies of the sixteen architectural registers. The speculative copy, called the future file, has a value, a valid bit and the reorder-buffer tag of its newest writer in each entry. The committed copy holds the retired state.

At issue, up to two source operands are read from the future file. If the entry is valid, the read returns a value. If it is not valid, the read returns the tag of the pending producer, and the consumer waits for that tag on the completion broadcast. In the same cycle, one destination entry can be claimed: it takes the issuing tag and its valid bit is cleared. A completion broadcast writes an entry only when that entry is still waiting and its stored tag equals the completing tag. Because of this, an older writer that was overtaken by a younger one does not touch the entry.

Retirement writes the committed copy. A recovery request, which arrives at retirement after a misprediction or an exception, copies every committed value into the future file and marks every entry valid.

Top module: `ffr_unit`

## Requirements
- R1: After reset, every future entry is valid with value 0 and every committed register holds 0, so any source read returns ready=1 and value 0.
- R2: A source read of a valid entry returns ready=1 and the stored value. A source read of a waiting entry that is not matched by a broadcast in the same cycle returns ready=0 and the stored tag in src_tag.
- R3: An allocation (alloc_en=1) sets the entry alloc_reg to waiting with tag alloc_tag from the next cycle on. Source reads in the allocating cycle still see the state from before the allocation.
- R4: A completion (wb_en=1) writes wb_data into an entry and makes it valid only if that entry is waiting and its stored tag equals wb_tag. Every other entry, including a valid one that holds the same tag, is left unchanged.
- R5: A retire (ret_en=1) writes ret_data into committed register ret_reg. A retire alone does not change the future file.
- R6: A recovery (recover=1) makes every future entry valid with its committed value in the next cycle. An allocation or completion presented in the same cycle is discarded.
- R7: When an allocation and a matching completion hit the same entry in one cycle, the allocation wins and the entry is left waiting on the new tag. A source read of that entry in that cycle returns ready=1 and wb_data through the bypass.
- R8: When a retire and a recovery occur in the same cycle, the recovered future entry for ret_reg holds ret_data.
- R9: The two source ports are independent. Both may name the same register, and each port i uses bits [4i+3:4i] of src_reg, [32i+31:32i] of src_value and [8i+7:8i] of src_tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_reg | input | 8 | Register index for each of the two source ports |
| src_ready | output | 2 | Per source port: 1 means the value is available |
| src_value | output | 64 | Per source port: operand value, meaningful when ready |
| src_tag | output | 16 | Per source port: producer tag, meaningful when not ready |
| alloc_en | input | 1 | Claim a destination entry this cycle |
| alloc_reg | input | 4 | Destination register index |
| alloc_tag | input | 8 | Reorder-buffer tag of the issuing instruction |
| wb_en | input | 1 | Completion broadcast valid |
| wb_tag | input | 8 | Tag of the completing instruction |
| wb_data | input | 32 | Result of the completing instruction |
| ret_en | input | 1 | Retire write valid |
| ret_reg | input | 4 | Retiring destination register |
| ret_data | input | 32 | Retiring result |
| recover | input | 1 | Copy the committed state into the future file |

## Verification
Completions are sent with these tags:
- a tag that matches a waiting entry, to show a normal fill;
- a tag that matches no entry, to show a clean miss;
- a tag held by a valid entry, to show that a valid entry is never rewritten;
- the tag of an overtaken older writer, to separate "last writer" from "any writer".

Allocation and completion are driven onto the same entry in one cycle, with a read of that entry, to show both allocation priority and the bypass. Recovery is driven on its own, with a retire in the same cycle, and with an allocation in the same cycle. Together these show that the committed copy is read after the retire write and that allocations are dropped during recovery.

// File: rtl/ffr_pkg.sv
package ffr_pkg;

  // Which update an entry of the future file takes in a given cycle.
  typedef enum logic [1:0] {
    UPD_HOLD    = 2'd0,
    UPD_RECOVER = 2'd1,
    UPD_ALLOC   = 2'd2,
    UPD_FILL    = 2'd3
  } upd_e;

  // Priority: recovery, then allocation, then a tag-matched fill.
  function automatic upd_e pick_update(input logic rec, input logic alloc, input logic fill);
    if (rec)        return UPD_RECOVER;
    else if (alloc) return UPD_ALLOC;
    else if (fill)  return UPD_FILL;
    else            return UPD_HOLD;
  endfunction

  // A fill needs a waiting entry whose stored tag equals the broadcast tag.
  function automatic logic tag_fill(input logic bcast, input logic waiting, input logic same_tag);
    return bcast && waiting && same_tag;
  endfunction

endpackage

// File: rtl/ffr_commit_file.sv
module ffr_commit_file #(
  parameter int NUM_ARCH = 16,
  parameter int DATA_W   = 32,
  localparam int REG_W   = $clog2(NUM_ARCH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ret_en,
  input  logic [REG_W-1:0]           ret_reg,
  input  logic [DATA_W-1:0]          ret_data,
  output logic [NUM_ARCH*DATA_W-1:0] rec_flat
);

  logic [DATA_W-1:0] com_q [NUM_ARCH];
  logic [NUM_ARCH-1:0] ret_hit;

  for (genvar i = 0; i < NUM_ARCH; i++) begin : g_reg
    assign ret_hit[i] = ret_en && (ret_reg == REG_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          com_q[i] <= '0;
      else if (ret_hit[i]) com_q[i] <= ret_data;
    end

    // The value recovery copies includes a retire in the same cycle.
    assign rec_flat[i*DATA_W +: DATA_W] = ret_hit[i] ? ret_data : com_q[i];

    AST_RETIRE_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
      ret_hit[i] |=> com_q[i] == $past(ret_data)); // R5
    AST_COMMIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !ret_hit[i] |=> $stable(com_q[i])); // R5
  end

endmodule

// File: rtl/ffr_future_file.sv
module ffr_future_file
  import ffr_pkg::*;
#(
  parameter int NUM_ARCH = 16,
  parameter int DATA_W   = 32,
  parameter int TAG_W    = 8,
  localparam int REG_W   = $clog2(NUM_ARCH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       alloc_en,
  input  logic [REG_W-1:0]           alloc_reg,
  input  logic [TAG_W-1:0]           alloc_tag,
  input  logic                       wb_en,
  input  logic [TAG_W-1:0]           wb_tag,
  input  logic [DATA_W-1:0]          wb_data,
  input  logic                       rec_en,
  input  logic [NUM_ARCH*DATA_W-1:0] rec_flat,
  output logic [NUM_ARCH*DATA_W-1:0] val_flat,
  output logic [NUM_ARCH*TAG_W-1:0]  tag_flat,
  output logic [NUM_ARCH-1:0]        vld
);

  logic [DATA_W-1:0] val_q [NUM_ARCH];
  logic [TAG_W-1:0]  tag_q [NUM_ARCH];
  logic [NUM_ARCH-1:0] alloc_hit;
  logic [NUM_ARCH-1:0] fill_hit;
  upd_e                upd [NUM_ARCH];

  for (genvar i = 0; i < NUM_ARCH; i++) begin : g_ent
    assign alloc_hit[i] = alloc_en && (alloc_reg == REG_W'(i));
    assign fill_hit[i]  = tag_fill(wb_en, !vld[i], tag_q[i] == wb_tag);
    assign upd[i]       = pick_update(rec_en, alloc_hit[i], fill_hit[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q[i] <= '0;
        tag_q[i] <= '0;
        vld[i]   <= 1'b1;
      end else begin
        case (upd[i])
          UPD_RECOVER: begin
            val_q[i] <= rec_flat[i*DATA_W +: DATA_W];
            vld[i]   <= 1'b1;
          end
          UPD_ALLOC: begin
            tag_q[i] <= alloc_tag;
            vld[i]   <= 1'b0;
          end
          UPD_FILL: begin
            val_q[i] <= wb_data;
            vld[i]   <= 1'b1;
          end
          default: ;
        endcase
      end
    end

    assign val_flat[i*DATA_W +: DATA_W] = val_q[i];
    assign tag_flat[i*TAG_W +: TAG_W]   = tag_q[i];

    AST_ALLOC_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_hit[i] && !rec_en) |=> (!vld[i] && tag_q[i] == $past(alloc_tag))); // R3
    AST_FILL_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_hit[i] && !alloc_hit[i] && !rec_en) |=> (vld[i] && val_q[i] == $past(wb_data))); // R4
    AST_MISS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!fill_hit[i] && !alloc_hit[i] && !rec_en) |=> ($stable(val_q[i]) && $stable(vld[i]))); // R4
    AST_RECOVER_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
      rec_en |=> (vld[i] && val_q[i] == $past(rec_flat[i*DATA_W +: DATA_W]))); // R6
  end

  AST_ONE_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(alloc_hit)); // R3

endmodule

// File: rtl/ffr_src_port.sv
module ffr_src_port #(
  parameter int NUM_ARCH = 16,
  parameter int DATA_W   = 32,
  parameter int TAG_W    = 8,
  localparam int REG_W   = $clog2(NUM_ARCH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [REG_W-1:0]           sel,
  input  logic [NUM_ARCH*DATA_W-1:0] val_flat,
  input  logic [NUM_ARCH*TAG_W-1:0]  tag_flat,
  input  logic [NUM_ARCH-1:0]        vld,
  input  logic                       wb_en,
  input  logic [TAG_W-1:0]           wb_tag,
  input  logic [DATA_W-1:0]          wb_data,
  output logic                       ready,
  output logic [DATA_W-1:0]          value,
  output logic [TAG_W-1:0]           tag
);

  logic [DATA_W-1:0] ent_val;
  logic [TAG_W-1:0]  ent_tag;
  logic              ent_vld;
  logic              bypass_hit;

  assign ent_val    = val_flat[int'(sel)*DATA_W +: DATA_W];
  assign ent_tag    = tag_flat[int'(sel)*TAG_W +: TAG_W];
  assign ent_vld    = vld[sel];
  assign bypass_hit = wb_en && !ent_vld && (ent_tag == wb_tag);

  always_comb begin
    ready = ent_vld || bypass_hit;
    tag   = ent_tag;
    if (ent_vld)         value = ent_val;
    else if (bypass_hit) value = wb_data;
    else                 value = '0;
  end

  AST_WAIT_GIVES_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (!vld[sel] && tag == tag_flat[int'(sel)*TAG_W +: TAG_W])); // R2
  AST_BYPASS_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !vld[sel]) |-> (wb_en && value == wb_data)); // R7

endmodule

// File: rtl/ffr_unit.sv
module ffr_unit #(
  parameter int NUM_ARCH = 16,
  parameter int DATA_W   = 32,
  parameter int TAG_W    = 8,
  parameter int N_SRC    = 2,
  localparam int REG_W   = $clog2(NUM_ARCH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_SRC*REG_W-1:0]   src_reg,
  output logic [N_SRC-1:0]         src_ready,
  output logic [N_SRC*DATA_W-1:0]  src_value,
  output logic [N_SRC*TAG_W-1:0]   src_tag,
  input  logic                     alloc_en,
  input  logic [REG_W-1:0]         alloc_reg,
  input  logic [TAG_W-1:0]         alloc_tag,
  input  logic                     wb_en,
  input  logic [TAG_W-1:0]         wb_tag,
  input  logic [DATA_W-1:0]        wb_data,
  input  logic                     ret_en,
  input  logic [REG_W-1:0]         ret_reg,
  input  logic [DATA_W-1:0]        ret_data,
  input  logic                     recover
);

  logic [NUM_ARCH*DATA_W-1:0] rec_flat;
  logic [NUM_ARCH*DATA_W-1:0] val_flat;
  logic [NUM_ARCH*TAG_W-1:0]  tag_flat;
  logic [NUM_ARCH-1:0]        vld;

  ffr_commit_file #(.NUM_ARCH(NUM_ARCH), .DATA_W(DATA_W)) u_commit (
    .clk(clk), .rst_n(rst_n), .ret_en(ret_en), .ret_reg(ret_reg),
    .ret_data(ret_data), .rec_flat(rec_flat)
  );

  ffr_future_file #(.NUM_ARCH(NUM_ARCH), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_future (
    .clk(clk), .rst_n(rst_n), .alloc_en(alloc_en), .alloc_reg(alloc_reg),
    .alloc_tag(alloc_tag), .wb_en(wb_en), .wb_tag(wb_tag), .wb_data(wb_data),
    .rec_en(recover), .rec_flat(rec_flat), .val_flat(val_flat),
    .tag_flat(tag_flat), .vld(vld)
  );

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    ffr_src_port #(.NUM_ARCH(NUM_ARCH), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_port (
      .clk(clk), .rst_n(rst_n), .sel(src_reg[s*REG_W +: REG_W]),
      .val_flat(val_flat), .tag_flat(tag_flat), .vld(vld),
      .wb_en(wb_en), .wb_tag(wb_tag), .wb_data(wb_data),
      .ready(src_ready[s]), .value(src_value[s*DATA_W +: DATA_W]),
      .tag(src_tag[s*TAG_W +: TAG_W])
    );
  end

  AST_RECOVER_ALL_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    recover |=> (&vld)); // R6
  AST_RESET_ALL_VALID: assert property (@(posedge clk)
    $rose(rst_n) |-> (&vld)); // R1
  AST_RETIRE_RECOVER_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_en && recover) |=> (val_flat[int'($past(ret_reg))*DATA_W +: DATA_W] == $past(ret_data))); // R8

endmodule

// File: tb/ffr_unit_tb.sv
module ffr_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  src_reg = '0;
  logic [1:0]  src_ready;
  logic [63:0] src_value;
  logic [15:0] src_tag;
  logic        alloc_en = 1'b0;
  logic [3:0]  alloc_reg = '0;
  logic [7:0]  alloc_tag = '0;
  logic        wb_en = 1'b0;
  logic [7:0]  wb_tag = '0;
  logic [31:0] wb_data = '0;
  logic        ret_en = 1'b0;
  logic [3:0]  ret_reg = '0;
  logic [31:0] ret_data = '0;
  logic        recover = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  ffr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .src_reg(src_reg), .src_ready(src_ready),
    .src_value(src_value), .src_tag(src_tag), .alloc_en(alloc_en),
    .alloc_reg(alloc_reg), .alloc_tag(alloc_tag), .wb_en(wb_en),
    .wb_tag(wb_tag), .wb_data(wb_data), .ret_en(ret_en), .ret_reg(ret_reg),
    .ret_data(ret_data), .recover(recover)
  );

  task automatic idle();
    alloc_en = 0; wb_en = 0; ret_en = 0; recover = 0;
  endtask

  // Let the current inputs be captured, then return at the next falling edge.
  task automatic tick();
    @(posedge clk); @(negedge clk); idle();
  endtask

  // Port p: expect ready, and then either the value or the tag.
  task automatic chk(input int p, input logic [3:0] r, input bit exp_rdy,
                     input logic [31:0] exp_val, input logic [7:0] exp_tag, input string req);
    logic        rdy;
    logic [31:0] v;
    logic [7:0]  t;
    if (p == 0) src_reg[3:0] = r; else src_reg[7:4] = r;
    #1;
    rdy = src_ready[p];
    v   = src_value[p*32 +: 32];
    t   = src_tag[p*8 +: 8];
    checks++;
    if (rdy !== exp_rdy || (exp_rdy && v !== exp_val) || (!exp_rdy && t !== exp_tag)) begin
      fails++;
      $display("FAIL %s port%0d reg%0d: actual rdy=%0b val=%h tag=%h expected rdy=%0b val=%h tag=%h",
               req, p, r, rdy, v, t, exp_rdy, exp_val, exp_tag);
    end
  endtask

  task automatic t_reset();
    for (int r = 0; r < 16; r++) chk(r % 2, 4'(r), 1, 0, 0, "R1");
  endtask

  task automatic t_alloc();
    alloc_en = 1; alloc_reg = 3; alloc_tag = 8'h15;
    chk(0, 3, 1, 0, 0, "R3");            // same-cycle read sees old state
    tick();
    chk(0, 3, 0, 0, 8'h15, "R3");
    chk(1, 4, 1, 0, 0, "R2");
  endtask

  task automatic t_fill();
    wb_en = 1; wb_tag = 8'h15; wb_data = 32'hDEAD_0003;
    tick();
    chk(0, 3, 1, 32'hDEAD_0003, 0, "R4");
    alloc_en = 1; alloc_reg = 4; alloc_tag = 8'h20;
    tick();
    wb_en = 1; wb_tag = 8'h21; wb_data = 32'h1111_1111;
    chk(0, 4, 0, 0, 8'h20, "R2");        // no match: still waiting
    tick();
    chk(0, 4, 0, 0, 8'h20, "R4");
    wb_en = 1; wb_tag = 8'h15; wb_data = 32'h2222_2222;
    tick();
    chk(0, 3, 1, 32'hDEAD_0003, 0, "R4"); // valid entry with same tag untouched
  endtask

  task automatic t_last_writer();
    alloc_en = 1; alloc_reg = 5; alloc_tag = 8'h30;
    tick();
    alloc_en = 1; alloc_reg = 5; alloc_tag = 8'h31;
    tick();
    wb_en = 1; wb_tag = 8'h30; wb_data = 32'h3030_3030;
    tick();
    chk(0, 5, 0, 0, 8'h31, "R4");
    wb_en = 1; wb_tag = 8'h31; wb_data = 32'h3131_3131;
    tick();
    chk(1, 5, 1, 32'h3131_3131, 0, "R4");
  endtask

  task automatic t_collide();
    alloc_en = 1; alloc_reg = 6; alloc_tag = 8'h40;
    tick();
    alloc_en = 1; alloc_reg = 6; alloc_tag = 8'h41;
    wb_en = 1; wb_tag = 8'h40; wb_data = 32'h4040_4040;
    chk(0, 6, 1, 32'h4040_4040, 0, "R7");
    chk(1, 6, 1, 32'h4040_4040, 0, "R9");
    tick();
    chk(0, 6, 0, 0, 8'h41, "R7");
  endtask

  task automatic t_dual();
    chk(0, 3, 1, 32'hDEAD_0003, 0, "R9");
    chk(1, 4, 0, 0, 8'h20, "R9");
    chk(1, 3, 1, 32'hDEAD_0003, 0, "R9");
  endtask

  task automatic t_recover();
    ret_en = 1; ret_reg = 9; ret_data = 32'h0000_0C09;
    tick();
    chk(0, 9, 1, 0, 0, "R5");            // retire leaves the future file alone
    ret_en = 1; ret_reg = 2; ret_data = 32'hAAAA_0002;
    tick();
    recover = 1; alloc_en = 1; alloc_reg = 7; alloc_tag = 8'h55;
    ret_en = 1; ret_reg = 8; ret_data = 32'hBBBB_0008;
    tick();
    chk(0, 2, 1, 32'hAAAA_0002, 0, "R6");
    chk(1, 9, 1, 32'h0000_0C09, 0, "R6");
    chk(0, 7, 1, 0, 0, "R6");            // allocation during recovery dropped
    chk(1, 3, 1, 0, 0, "R6");            // speculative value discarded
    chk(0, 4, 1, 0, 0, "R6");
    chk(1, 8, 1, 32'hBBBB_0008, 0, "R8");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R0 watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_alloc();
    t_fill();
    t_last_writer();
    t_collide();
    t_dual();
    t_recover();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule